// File: doc/BRIEF.md
# Event-Mode Performance Counter Unit

This block gives a processor core three hardware counters for profiling: a cycle counter that runs whenever counting is enabled, and two event counters, A and B. A two-bit mode field chooses which pair of core events drives A and B. Each mode pairs a per-cycle or multi-increment count on A with an occurrence count of a related event on B. Software divides the counts afterwards, for example A by the cycle count to get a stall percentage, or A by B to get the average length of a stall.

The modes are:
- **Data-cache efficiency.** A adds the number of data-cache accesses made in the cycle, from zero to seven. B adds the data-cache and mini-data-cache misses, but not misses caused by cache maintenance.
- **Fetch latency.** A counts the cycles in which the instruction cache stalls, whether on a cache miss or a translation miss. B counts the 32-byte line-fill requests sent to external memory.
- **Buffer-full.** A counts the cycles in which no data-cache request buffer is free. B counts how many times that stall begins.

Software drives the block through a small synchronous register port. Writes take effect on the clock edge, and reads are combinational. Every event input is a plain level, sampled on each rising clock edge. The block has no data stream, so there is no handshake and no back-pressure. Each counter has a sticky overflow flag, also brought out as a pin.

Top module: `perf_event_counters`

## Requirements
- R1: After reset, all three counters read 0, all overflow flags are 0, the control register reads 0 (disabled, mode 0), and every event input is ignored.
- R2: While enable (control bit 0) is 1, the cycle counter increases by one on every clock. While enable is 0, no counter changes except by a clear.
- R3: In mode 0 (data-cache efficiency), counter A adds the 3-bit access count `ev_acc_cnt` (0 to 7) in a single clock.
- R4: In mode 0, counter B adds one for each of `ev_dc_miss` and `ev_mdc_miss` that is high, so it can add two in one clock. It adds nothing in a clock where `ev_maint_op` is high.
- R5: In mode 1 (fetch latency), counter A adds one in each clock where `ev_ic_miss_stall` or `ev_itlb_miss_stall` is high. Counter B adds one per clock with `ev_ext_fetch` high.
- R6: In mode 2 (buffer-full), counter A adds one in each clock where `ev_buf_full` is high. Counter B adds one only on the clock where `ev_buf_full` is high after being low on the previous clock.
- R7: In mode 3, neither event counter changes. Event inputs that belong to modes other than the current one never affect A or B.
- R8: Writing the control register with bit 1 set sets all three counters to 0 at that edge, with no count added. The same write loads enable and mode. The overflow flags are not changed.
- R9: A mode written at one edge governs counting from the next edge onward, and the write alone does not clear any counter.
- R10: Counters wrap modulo 2^CNT_W. A carry out of a counter sets its sticky flag: bit 0 for the cycle counter, bit 1 for A, bit 2 for B. Writing 1 to a flag bit at register 1 clears that flag, except that a new overflow in the same clock wins.
- R11: Register map, read side: 0 is control (bit 0 enable, bits 3:2 mode, bit 1 always reads 0), 1 is the overflow flags, 2 is the cycle counter, 3 is counter A, 4 is counter B. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, acts at the rising edge |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| ev_acc_cnt | input | INC_W | Data-cache accesses made this clock |
| ev_dc_miss | input | 1 | Data-cache miss this clock |
| ev_mdc_miss | input | 1 | Mini-data-cache miss this clock |
| ev_maint_op | input | 1 | This clock's miss signals come from a cache maintenance operation |
| ev_ic_miss_stall | input | 1 | Fetch stalled on an instruction-cache miss |
| ev_itlb_miss_stall | input | 1 | Fetch stalled on an instruction translation miss |
| ev_ext_fetch | input | 1 | Instruction line-fill request issued to external memory |
| ev_buf_full | input | 1 | Core stalled because no data-cache request buffer is free |
| ovf_flags | output | 3 | Sticky overflow flags {B, A, cycle} |

## Verification
A table of single-clock event patterns is applied in every mode. Some patterns drive several event inputs at once, so the bench can tell whether a counter picks the right source or counts inputs that belong to another mode. It also checks the weighted access count against a plain count of one, and two misses in one clock against one. Directed runs then hold the buffer-full stall across several clocks, to separate counting cycles from counting episodes. They also write a new mode while conflicting events are active, to pin down the cycle in which the mode changes. Finally, a long run of seven-per-clock increments wraps counter A, which exercises the carry, the sticky flag, the flag surviving a clear, and write-one-to-clear.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  typedef enum logic [1:0] {
    MODE_DC_EFF   = 2'd0,
    MODE_IF_LAT   = 2'd1,
    MODE_BUF_FULL = 2'd2,
    MODE_OFF      = 2'd3
  } pmu_mode_e;

  localparam int ADDR_W   = 3;
  localparam int NUM_CNT  = 3;   // 0: cycles, 1: event A, 2: event B
  localparam int IDX_CYC  = 0;
  localparam int IDX_A    = 1;
  localparam int IDX_B    = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_OVF      = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT_BASE = 3'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 2;
endpackage

// File: rtl/pmu_event_mux.sv
`timescale 1ns/1ps
module pmu_event_mux
  import pmu_pkg::*;
#(
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pmu_mode_e        mode,
  input  logic [INC_W-1:0] acc_cnt,
  input  logic             dc_miss,
  input  logic             mdc_miss,
  input  logic             maint_op,
  input  logic             ic_stall,
  input  logic             itlb_stall,
  input  logic             ext_fetch,
  input  logic             buf_full,
  output logic [INC_W-1:0] inc_a,
  output logic [INC_W-1:0] inc_b
);
  logic buf_full_d;

  // Previous-cycle copy of the stall level, used to find episode starts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_full_d <= 1'b0;
    else        buf_full_d <= buf_full;
  end

  always_comb begin
    inc_a = '0;
    inc_b = '0;
    unique case (mode)
      MODE_DC_EFF: begin
        inc_a = acc_cnt;
        inc_b = maint_op ? '0 : INC_W'(dc_miss) + INC_W'(mdc_miss);
      end
      MODE_IF_LAT: begin
        inc_a = INC_W'(ic_stall | itlb_stall);
        inc_b = INC_W'(ext_fetch);
      end
      MODE_BUF_FULL: begin
        inc_a = INC_W'(buf_full);
        inc_b = INC_W'(buf_full & ~buf_full_d);
      end
      default: begin
        inc_a = '0;
        inc_b = '0;
      end
    endcase
  end
endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int SUM_W = CNT_W + 1;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, cnt} + SUM_W'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= sum[CNT_W-1:0];
  end

  // Sticky carry flag: a fresh overflow outranks a clear request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovf <= 1'b0;
    else if (en && !clr && sum[CNT_W]) ovf <= 1'b1;
    else if (ovf_clr)               ovf <= 1'b0;
  end
endmodule

// File: rtl/pmu_regs.sv
`timescale 1ns/1ps
module pmu_regs
  import pmu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec,
  input  logic [NUM_CNT-1:0]            ovf_vec,
  output logic                          en_q,
  output pmu_mode_e                     mode_q,
  output logic                          clr_pulse,
  output logic [NUM_CNT-1:0]            ovf_w1c,
  output logic [DATA_W-1:0]             reg_rdata
);
  logic ctrl_wr;

  assign ctrl_wr   = reg_we && (reg_addr == ADDR_CTRL);
  assign clr_pulse = ctrl_wr && reg_wdata[CTRL_CLR_BIT];
  assign ovf_w1c   = (reg_we && (reg_addr == ADDR_OVF)) ? reg_wdata[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_DC_EFF;
    end else if (ctrl_wr) begin
      en_q   <= reg_wdata[CTRL_EN_BIT];
      mode_q <= pmu_mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL)
      reg_rdata = DATA_W'({mode_q, 1'b0, en_q});
    else if (reg_addr == ADDR_OVF)
      reg_rdata = DATA_W'(ovf_vec);
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_CNT_BASE + ADDR_W'(i))
        reg_rdata = DATA_W'(cnt_vec[i]);
    end
  end
endmodule

// File: rtl/perf_event_counters.sv
`timescale 1ns/1ps
module perf_event_counters
  import pmu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int INC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [INC_W-1:0]  ev_acc_cnt,
  input  logic              ev_dc_miss,
  input  logic              ev_mdc_miss,
  input  logic              ev_maint_op,
  input  logic              ev_ic_miss_stall,
  input  logic              ev_itlb_miss_stall,
  input  logic              ev_ext_fetch,
  input  logic              ev_buf_full,
  output logic [2:0]        ovf_flags
);
  logic                          en_q;
  pmu_mode_e                     mode_q;
  logic                          clr_pulse;
  logic [NUM_CNT-1:0]            ovf_w1c;
  logic [NUM_CNT-1:0]            ovf_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_CNT-1:0][INC_W-1:0] inc_vec;
  logic [INC_W-1:0]              inc_a;
  logic [INC_W-1:0]              inc_b;

  pmu_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_vec   (cnt_vec),
    .ovf_vec   (ovf_vec),
    .en_q      (en_q),
    .mode_q    (mode_q),
    .clr_pulse (clr_pulse),
    .ovf_w1c   (ovf_w1c),
    .reg_rdata (reg_rdata)
  );

  pmu_event_mux #(.INC_W(INC_W)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .acc_cnt    (ev_acc_cnt),
    .dc_miss    (ev_dc_miss),
    .mdc_miss   (ev_mdc_miss),
    .maint_op   (ev_maint_op),
    .ic_stall   (ev_ic_miss_stall),
    .itlb_stall (ev_itlb_miss_stall),
    .ext_fetch  (ev_ext_fetch),
    .buf_full   (ev_buf_full),
    .inc_a      (inc_a),
    .inc_b      (inc_b)
  );

  assign inc_vec[IDX_CYC] = INC_W'(1);
  assign inc_vec[IDX_A]   = inc_a;
  assign inc_vec[IDX_B]   = inc_b;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    pmu_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_pulse),
      .en      (en_q),
      .inc     (inc_vec[g]),
      .ovf_clr (ovf_w1c[g]),
      .cnt     (cnt_vec[g]),
      .ovf     (ovf_vec[g])
    );
  end

  assign ovf_flags = ovf_vec;
endmodule

// File: rtl/pmu_checker.sv
`timescale 1ns/1ps
module pmu_checker #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              ev_ic_miss_stall,
  input logic              ev_itlb_miss_stall,
  input logic              ev_buf_full,
  input logic              en_q,
  input logic [1:0]        mode_q,
  input logic [CNT_W-1:0]  cnt_cyc,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [CNT_W-1:0]  cnt_b,
  input logic [2:0]        ovf_flags
);
  logic clr_wr;
  logic ovf_wr;
  assign clr_wr = reg_we && (reg_addr == 3'd0) && reg_wdata[1];
  assign ovf_wr = reg_we && (reg_addr == 3'd1);

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (cnt_cyc == '0 && cnt_a == '0 && cnt_b == '0 && ovf_flags == 3'b000));

  assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !clr_wr) |=> cnt_cyc == CNT_W'($past(cnt_cyc) + 1'b1));

  assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_wr) |=> ($stable(cnt_cyc) && $stable(cnt_a) && $stable(cnt_b)));

  assert_fetch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && !clr_wr && !ev_ic_miss_stall && !ev_itlb_miss_stall) |=> $stable(cnt_a));

  assert_episode_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && !clr_wr && ev_buf_full && $past(ev_buf_full)) |=> $stable(cnt_b));

  assert_mode_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3 && !clr_wr) |=> ($stable(cnt_a) && $stable(cnt_b)));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt_cyc == '0 && cnt_a == '0 && cnt_b == '0));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_wr && ovf_flags != 3'b000) |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));
endmodule

bind perf_event_counters pmu_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .reg_we             (reg_we),
  .reg_addr           (reg_addr),
  .reg_wdata          (reg_wdata),
  .ev_ic_miss_stall   (ev_ic_miss_stall),
  .ev_itlb_miss_stall (ev_itlb_miss_stall),
  .ev_buf_full        (ev_buf_full),
  .en_q               (en_q),
  .mode_q             (mode_q),
  .cnt_cyc            (cnt_vec[0]),
  .cnt_a              (cnt_vec[1]),
  .cnt_b              (cnt_vec[2]),
  .ovf_flags          (ovf_flags)
);

// File: tb/perf_event_counters_tb.sv
`timescale 1ns/1ps
module perf_event_counters_tb;
  localparam int CW = 8;
  localparam logic [2:0] A_CTRL = 3'd0, A_OVF = 3'd1, A_CYC = 3'd2, A_EVA = 3'd3, A_EVB = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  ev_acc_cnt = '0;
  logic ev_dc_miss = 0, ev_mdc_miss = 0, ev_maint_op = 0, ev_ic_miss_stall = 0;
  logic ev_itlb_miss_stall = 0, ev_ext_fetch = 0, ev_buf_full = 0;
  logic [2:0]  ovf_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  perf_event_counters #(.CNT_W(CW), .DATA_W(32), .INC_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_acc_cnt(ev_acc_cnt),
    .ev_dc_miss(ev_dc_miss), .ev_mdc_miss(ev_mdc_miss), .ev_maint_op(ev_maint_op),
    .ev_ic_miss_stall(ev_ic_miss_stall), .ev_itlb_miss_stall(ev_itlb_miss_stall),
    .ev_ext_fetch(ev_ext_fetch), .ev_buf_full(ev_buf_full), .ovf_flags(ovf_flags)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] acc;
    logic dcm, mdcm, mnt, ics, its, ext, bf;
    logic [3:0] ea, eb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 4'd0},
    '{2'd0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7, 4'd1},
    '{2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd2},
    '{2'd0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 4'd0},
    '{2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    '{2'd1, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 4'd0},
    '{2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 4'd1},
    '{2'd1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 4'd1},
    '{2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 4'd0},
    '{2'd2, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1, 4'd1},
    '{2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    '{2'd3, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0}
  };

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R3/R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // All tasks are entered in the low phase of the clock.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ev_set(input vec_t v);
    ev_acc_cnt = v.acc; ev_dc_miss = v.dcm; ev_mdc_miss = v.mdcm; ev_maint_op = v.mnt;
    ev_ic_miss_stall = v.ics; ev_itlb_miss_stall = v.its; ev_ext_fetch = v.ext; ev_buf_full = v.bf;
  endtask

  task automatic ev_idle();
    ev_acc_cnt = '0; ev_dc_miss = 0; ev_mdc_miss = 0; ev_maint_op = 0;
    ev_ic_miss_stall = 0; ev_itlb_miss_stall = 0; ev_ext_fetch = 0; ev_buf_full = 0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [1:0] m, input bit en, input bit clr);
    return {28'd0, m, clr, en};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // Events active during and after reset must not be counted while disabled.
    ev_acc_cnt = 3'd4; ev_buf_full = 1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ev_idle();

    rd(A_CTRL, d); chk("R1", "ctrl after reset", d, 32'd0);
    rd(A_OVF, d);  chk("R1", "flags after reset", d, 32'd0);
    rd(A_CYC, d);  chk("R1", "cycle count after reset", d, 32'd0);
    rd(A_EVA, d);  chk("R1", "counter A after reset", d, 32'd0);
    rd(A_EVB, d);  chk("R1", "counter B after reset", d, 32'd0);
    rd(3'd7, d);   chk("R11", "unmapped address", d, 32'd0);

    // R2: cycle counter runs one per clock while enabled.
    wr(A_CTRL, ctrl_word(2'd2, 1, 1));
    rd(A_CTRL, d); chk("R11", "ctrl readback mode 2 enabled", d, 32'h9);
    @(negedge clk);
    repeat (4) @(negedge clk);
    rd(A_CYC, d); chk("R2", "cycle count after 5 clocks", d, 32'd5);

    // R2: disabled, nothing moves even with events active.
    wr(A_CTRL, ctrl_word(2'd2, 0, 1));
    ev_buf_full = 1; ev_acc_cnt = 3'd7;
    repeat (4) @(negedge clk);
    ev_idle();
    rd(A_CYC, d); chk("R2", "cycle count while disabled", d, 32'd0);
    rd(A_EVA, d); chk("R2", "counter A while disabled", d, 32'd0);
    @(negedge clk);

    // Table of single-clock event patterns.
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, ctrl_word(VEC[i].mode, 1, 1));
      ev_set(VEC[i]);
      @(negedge clk);
      ev_idle();
      rd(A_EVA, d); chk(mode_tag(VEC[i].mode), $sformatf("vector %0d counter A", i), d, 32'(VEC[i].ea));
      rd(A_EVB, d); chk(mode_tag(VEC[i].mode), $sformatf("vector %0d counter B", i), d, 32'(VEC[i].eb));
    end

    // R6: two stall episodes of 4 and 3 cycles.
    wr(A_CTRL, ctrl_word(2'd2, 1, 1));
    ev_buf_full = 1; repeat (4) @(negedge clk);
    ev_buf_full = 0; repeat (2) @(negedge clk);
    ev_buf_full = 1; repeat (3) @(negedge clk);
    ev_buf_full = 0;
    rd(A_EVA, d); chk("R6", "stall cycles over two episodes", d, 32'd7);
    rd(A_EVB, d); chk("R6", "episodes counted", d, 32'd2);

    // R9: mode switch applies from the next edge and keeps counts.
    wr(A_CTRL, ctrl_word(2'd0, 1, 1));
    ev_acc_cnt = 3'd5; @(negedge clk); ev_idle();
    ev_acc_cnt = 3'd3; ev_ic_miss_stall = 1;
    wr(A_CTRL, ctrl_word(2'd1, 1, 0));
    ev_idle();
    rd(A_EVA, d); chk("R9", "old mode governs write cycle", d, 32'd8);
    ev_ic_miss_stall = 1; ev_acc_cnt = 3'd7;
    repeat (2) @(negedge clk);
    ev_idle();
    rd(A_EVA, d); chk("R9", "new mode after switch, no clear", d, 32'd10);

    // R10: wrap of counter A with sticky flag.
    wr(A_CTRL, ctrl_word(2'd0, 1, 1));
    wr(A_OVF, 32'h7);
    ev_acc_cnt = 3'd7; repeat (36) @(negedge clk); ev_idle();
    rd(A_EVA, d); chk("R3", "counter A at 252", d, 32'd252);
    rd(A_OVF, d); chk("R10", "A flag before wrap", (d >> 1) & 32'd1, 32'd0);
    ev_acc_cnt = 3'd7; @(negedge clk); ev_idle();
    rd(A_EVA, d); chk("R10", "counter A wrapped", d, 32'd3);
    rd(A_OVF, d); chk("R10", "A flag set on wrap", (d >> 1) & 32'd1, 32'd1);
    chk("R10", "A flag pin", 32'(ovf_flags[1]), 32'd1);
    wr(A_CTRL, ctrl_word(2'd0, 1, 1));
    rd(A_EVA, d); chk("R8", "clear zeroes counter A", d, 32'd0);
    rd(A_OVF, d); chk("R8", "clear keeps A flag", (d >> 1) & 32'd1, 32'd1);
    wr(A_OVF, 32'h2);
    rd(A_OVF, d); chk("R10", "write-one clears A flag", (d >> 1) & 32'd1, 32'd0);

    finish_run();
  end
endmodule